// File: doc/BRIEF.md
# VLIW Execution-Set Predication Unit

This block sits in the dispatch stage of a VLIW DSP. For one execution set it turns group-level prefix conditions and per-instruction conditions into a mask of execute enables, one bit per issue slot. The prefix can carry one condition for each of two subgroups. Every slot is tagged with the subgroup it belongs to. A slot fires only when its subgroup condition holds and its own condition also holds. Both conditions are tested against the T flag as it stands in the dispatch cycle.

The block also rejects sets that it cannot execute legally. One case is a group-condition instruction placed as a member inside a subgroup. The other is a reserved condition code. In either case the illegal-grouping flag is raised and every enable of that set is forced to zero. Both outputs are registered, so they appear one cycle after dispatch.

Top module: `vles_pred_unit`

## Requirements
- R1: A subgroup whose prefix code is 01 (if true) enables its slots only when the dispatch-cycle T flag is 1.
- R2: A subgroup whose prefix code is 10 (if false) enables its slots only when the dispatch-cycle T flag is 0.
- R3: A prefix code of 00 (none or always) enables its subgroup regardless of T. When both prefix codes are 00, every valid slot executes unconditionally.
- R4: slotGroup bit i = 0 puts slot i in subgroup 1, which is governed by grpCond1. A value of 1 puts it in subgroup 2, which is governed by grpCond2. The two subgroups are evaluated independently.
- R5: Each slot has an own-condition field at slotCond[2i+1:2i] that uses the same codes: 00 = none, 01 = T set, 10 = T clear. A slot is enabled only if its subgroup condition and its own condition are both satisfied.
- R6: If any valid slot has slotIsIfc set (a group-condition instruction nested as a member), illegalGrp is 1 and all enables are 0 for that set. Invalid slots are not examined.
- R7: Code 11 is reserved. It raises illegalGrp and clears all enables when it appears in either prefix code, or in the own condition of a valid slot.
- R8: Enables of invalid slots are 0. When setValid is 0, the enables and illegalGrp are all 0.
- R9: Outputs follow the dispatch-cycle inputs with exactly one clock of latency. They hold until the next edge, even if tFlag changes in between.
- R10: A synchronous active-high reset clears execEn and illegalGrp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setValid | input | 1 | An execution set is presented this cycle |
| slotValid | input | NUM_SLOTS | Per-slot instruction present |
| slotGroup | input | NUM_SLOTS | Per-slot subgroup tag (0 = subgroup 1, 1 = subgroup 2) |
| slotCond | input | 2*NUM_SLOTS | Per-slot own condition codes |
| slotIsIfc | input | NUM_SLOTS | Slot holds a group-condition instruction |
| grpCond1 | input | 2 | Prefix condition of subgroup 1 |
| grpCond2 | input | 2 | Prefix condition of subgroup 2 |
| tFlag | input | 1 | Current T flag from the status register |
| execEn | output | NUM_SLOTS | Registered per-slot execute enables |
| illegalGrp | output | 1 | Registered illegal-grouping flag |

## Verification
The bound checker watches, on every cycle, the properties that concern the whole set. An illegal set must show no enables. A set that is not valid must produce silence. No enable may appear on a slot that was not valid. A reserved prefix code or a nested group condition must raise the flag, and a false subgroup-1 prefix must block every slot tagged to subgroup 1.

Other behaviours need chosen stimulus and are shown only by the bench's scenarios. These are the exact per-slot masks that result from mixing the two subgroups, the AND with each slot's own condition, the fact that invalid slots are ignored for the nesting check, and the outputs holding steady while T moves.

// File: rtl/pred_pkg.sv
package pred_pkg;

  typedef enum logic [1:0] {
    COND_NONE  = 2'b00,
    COND_T     = 2'b01,
    COND_NOT_T = 2'b10,
    COND_RSVD  = 2'b11
  } cond_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // a set is being dispatched
    logic squash;   // the set is illegal; drop all enables
  } predStrobe_t;

  function automatic logic condMet(input logic [1:0] code, input logic t);
    case (cond_e'(code))
      COND_NONE:  condMet = 1'b1;
      COND_T:     condMet = t;
      COND_NOT_T: condMet = ~t;
      default:    condMet = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pred_ctrl.sv
module pred_ctrl
  import pred_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   setValid,
  input  logic [NUM_SLOTS-1:0]   slotValid,
  input  logic [2*NUM_SLOTS-1:0] slotCond,
  input  logic [NUM_SLOTS-1:0]   slotIsIfc,
  input  logic [1:0]             grpCond1,
  input  logic [1:0]             grpCond2,
  output predStrobe_t            strobe,
  output logic                   illegalGrp
);

  logic [NUM_SLOTS-1:0] ownRsvd;
  logic nestedHit;
  logic prefixRsvd;
  logic badSet;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_rsvd
    assign ownRsvd[i] = slotValid[i] && (slotCond[2*i +: 2] == COND_RSVD);
  end

  always_comb begin
    nestedHit  = |(slotValid & slotIsIfc);
    prefixRsvd = (grpCond1 == COND_RSVD) || (grpCond2 == COND_RSVD);
    badSet     = nestedHit || prefixRsvd || (|ownRsvd);
    strobe.capture = setValid;
    strobe.squash  = setValid && badSet;
  end

  always_ff @(posedge clk) begin
    if (rst) illegalGrp <= 1'b0;
    else     illegalGrp <= strobe.squash;
  end

endmodule

// File: rtl/pred_datapath.sv
module pred_datapath
  import pred_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  predStrobe_t            strobe,
  input  logic [NUM_SLOTS-1:0]   slotValid,
  input  logic [NUM_SLOTS-1:0]   slotGroup,
  input  logic [2*NUM_SLOTS-1:0] slotCond,
  input  logic [1:0]             grpCond1,
  input  logic [1:0]             grpCond2,
  input  logic                   tFlag,
  output logic [NUM_SLOTS-1:0]   execEn
);

  logic grpOk1;
  logic grpOk2;
  logic [NUM_SLOTS-1:0] enNext;

  // one T sample shared by every evaluation of the set
  always_comb begin
    grpOk1 = condMet(grpCond1, tFlag);
    grpOk2 = condMet(grpCond2, tFlag);
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic groupOk;
    logic ownOk;
    assign groupOk   = slotGroup[i] ? grpOk2 : grpOk1;
    assign ownOk     = condMet(slotCond[2*i +: 2], tFlag);
    assign enNext[i] = strobe.capture && !strobe.squash &&
                       slotValid[i] && groupOk && ownOk;
  end

  always_ff @(posedge clk) begin
    if (rst) execEn <= '0;
    else     execEn <= enNext;
  end

endmodule

// File: rtl/vles_pred_unit.sv
module vles_pred_unit
  import pred_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   setValid,
  input  logic [NUM_SLOTS-1:0]   slotValid,
  input  logic [NUM_SLOTS-1:0]   slotGroup,
  input  logic [2*NUM_SLOTS-1:0] slotCond,
  input  logic [NUM_SLOTS-1:0]   slotIsIfc,
  input  logic [1:0]             grpCond1,
  input  logic [1:0]             grpCond2,
  input  logic                   tFlag,
  output logic [NUM_SLOTS-1:0]   execEn,
  output logic                   illegalGrp
);

  predStrobe_t strobe;

  pred_ctrl #(.NUM_SLOTS(NUM_SLOTS)) i_ctrl (
    .clk(clk), .rst(rst), .setValid(setValid), .slotValid(slotValid),
    .slotCond(slotCond), .slotIsIfc(slotIsIfc), .grpCond1(grpCond1),
    .grpCond2(grpCond2), .strobe(strobe), .illegalGrp(illegalGrp)
  );

  pred_datapath #(.NUM_SLOTS(NUM_SLOTS)) i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .slotValid(slotValid),
    .slotGroup(slotGroup), .slotCond(slotCond), .grpCond1(grpCond1),
    .grpCond2(grpCond2), .tFlag(tFlag), .execEn(execEn)
  );

endmodule

// File: rtl/vles_pred_unit_chk.sv
module vles_pred_unit_chk #(
  parameter int NUM_SLOTS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 setValid,
  input logic [NUM_SLOTS-1:0] slotValid,
  input logic [NUM_SLOTS-1:0] slotGroup,
  input logic [NUM_SLOTS-1:0] slotIsIfc,
  input logic [1:0]           grpCond1,
  input logic [1:0]           grpCond2,
  input logic                 tFlag,
  input logic [NUM_SLOTS-1:0] execEn,
  input logic                 illegalGrp
);

  // R6
  illegal_silent_chk: assert property (@(posedge clk) disable iff (rst)
    illegalGrp |-> execEn == '0);

  // R6
  nested_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (setValid && |(slotValid & slotIsIfc)) |=> illegalGrp);

  // R7
  rsvd_prefix_chk: assert property (@(posedge clk) disable iff (rst)
    (setValid && (grpCond1 == 2'b11 || grpCond2 == 2'b11)) |=> illegalGrp);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !setValid |=> (execEn == '0 && !illegalGrp));

  // R8
  invalid_slot_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (execEn & ~$past(slotValid)) == '0);

  // R1
  ift_block_chk: assert property (@(posedge clk) disable iff (rst)
    (setValid && grpCond1 == 2'b01 && !tFlag && slotGroup == '0) |=> execEn == '0);

  // R2
  iff_block_chk: assert property (@(posedge clk) disable iff (rst)
    (setValid && grpCond1 == 2'b10 && tFlag && slotGroup == '0) |=> execEn == '0);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (execEn == '0 && !illegalGrp));

endmodule

bind vles_pred_unit vles_pred_unit_chk #(.NUM_SLOTS(NUM_SLOTS)) i_chk (
  .clk(clk), .rst(rst), .setValid(setValid), .slotValid(slotValid),
  .slotGroup(slotGroup), .slotIsIfc(slotIsIfc), .grpCond1(grpCond1),
  .grpCond2(grpCond2), .tFlag(tFlag), .execEn(execEn), .illegalGrp(illegalGrp)
);

// File: tb/test_vles_pred_unit.sv
module test_vles_pred_unit;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  typedef struct packed {
    logic [7:0]  v;
    logic [7:0]  g;
    logic [15:0] c;
    logic [7:0]  n;
    logic [1:0]  g1;
    logic [1:0]  g2;
    logic        t;
    logic [7:0]  e;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{8'hFF, 8'h00, 16'h0000, 8'h00, 2'b00, 2'b00, 1'b0, 8'hFF, 1'b0, 4'd3}, // R3
    '{8'hFF, 8'h00, 16'h0000, 8'h00, 2'b01, 2'b00, 1'b1, 8'hFF, 1'b0, 4'd1}, // R1
    '{8'hFF, 8'h00, 16'h0000, 8'h00, 2'b01, 2'b00, 1'b0, 8'h00, 1'b0, 4'd1}, // R1
    '{8'hFF, 8'h00, 16'h0000, 8'h00, 2'b10, 2'b00, 1'b0, 8'hFF, 1'b0, 4'd2}, // R2
    '{8'hFF, 8'h00, 16'h0000, 8'h00, 2'b10, 2'b00, 1'b1, 8'h00, 1'b0, 4'd2}, // R2
    '{8'hFF, 8'hF0, 16'h0000, 8'h00, 2'b01, 2'b10, 1'b1, 8'h0F, 1'b0, 4'd4}, // R4
    '{8'hFF, 8'hF0, 16'h0000, 8'h00, 2'b01, 2'b10, 1'b0, 8'hF0, 1'b0, 4'd4}, // R4
    '{8'hFF, 8'h00, 16'h0009, 8'h00, 2'b00, 2'b00, 1'b1, 8'hFD, 1'b0, 4'd5}, // R5
    '{8'hFF, 8'h00, 16'h0002, 8'h00, 2'b01, 2'b00, 1'b1, 8'hFE, 1'b0, 4'd5}, // R5
    '{8'h35, 8'h00, 16'h0000, 8'h00, 2'b00, 2'b00, 1'b0, 8'h35, 1'b0, 4'd8}, // R8
    '{8'hFF, 8'h00, 16'h0000, 8'h04, 2'b00, 2'b00, 1'b0, 8'h00, 1'b1, 4'd6}, // R6
    '{8'h0F, 8'h00, 16'h0000, 8'h80, 2'b00, 2'b00, 1'b0, 8'h0F, 1'b0, 4'd6}, // R6
    '{8'hFF, 8'h00, 16'h0000, 8'h00, 2'b00, 2'b11, 1'b0, 8'h00, 1'b1, 4'd7}, // R7
    '{8'hFF, 8'h00, 16'h00C0, 8'h00, 2'b00, 2'b00, 1'b0, 8'h00, 1'b1, 4'd7}  // R7
  };

  logic clk = 1'b0;
  logic rst;
  logic setValid;
  logic [N-1:0] slotValid, slotGroup, slotIsIfc;
  logic [2*N-1:0] slotCond;
  logic [1:0] grpCond1, grpCond2;
  logic tFlag;
  logic [N-1:0] execEn;
  logic illegalGrp;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vles_pred_unit #(.NUM_SLOTS(N)) i_vles_pred_unit (
    .clk(clk), .rst(rst), .setValid(setValid), .slotValid(slotValid),
    .slotGroup(slotGroup), .slotCond(slotCond), .slotIsIfc(slotIsIfc),
    .grpCond1(grpCond1), .grpCond2(grpCond2), .tFlag(tFlag),
    .execEn(execEn), .illegalGrp(illegalGrp)
  );

  task automatic check(input string tag, input logic [7:0] gotE, input logic [7:0] expE,
                       input logic gotI, input logic expI);
    checks++;
    if (gotE !== expE || gotI !== expI) begin
      fails++;
      $display("FAIL %s: execEn=%h illegalGrp=%b expected execEn=%h illegalGrp=%b",
               tag, gotE, gotI, expE, expI);
    end
  endtask

  task automatic drive(input vec_t x, input logic sv);
    @(negedge clk);
    setValid  = sv;
    slotValid = x.v;
    slotGroup = x.g;
    slotCond  = x.c;
    slotIsIfc = x.n;
    grpCond1  = x.g1;
    grpCond2  = x.g2;
    tFlag     = x.t;
  endtask

  initial begin
    vec_t idle;
    idle = '0;
    rst = 1'b1;
    setValid = 1'b0; slotValid = '0; slotGroup = '0; slotCond = '0;
    slotIsIfc = '0; grpCond1 = '0; grpCond2 = '0; tFlag = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset", execEn, 8'h00, illegalGrp, 1'b0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i], 1'b1);
      @(posedge clk); #1;
      check($sformatf("R%0d vector %0d", VEC[i].req, i),
            execEn, VEC[i].e, illegalGrp, VEC[i].ill);
    end

    // R8: setValid low with an otherwise enabling set
    drive(VEC[0], 1'b0);
    @(posedge clk); #1;
    check("R8 set not valid", execEn, 8'h00, illegalGrp, 1'b0);

    // R9: latency and holding while T moves after dispatch
    drive(VEC[1], 1'b1);            // IFT, T=1 -> all enabled
    #1;
    check("R9 before edge", execEn, 8'h00, illegalGrp, 1'b0);
    @(posedge clk); #1;
    check("R9 after edge", execEn, 8'hFF, illegalGrp, 1'b0);
    tFlag = 1'b0;
    #2;
    check("R9 hold on T change", execEn, 8'hFF, illegalGrp, 1'b0);

    // R10: reset clears an illegal result
    drive(VEC[10], 1'b1);
    @(posedge clk); #1;
    check("R6 nested before reset", execEn, 8'h00, illegalGrp, 1'b1);
    drive(VEC[0], 1'b1);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R10 reset over valid set", execEn, 8'h00, illegalGrp, 1'b0);
    @(negedge clk); rst = 1'b0;
    drive(idle, 1'b0);
    @(posedge clk); #1;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule